// File: doc/BRIEF.md
# Paged Edge-Interrupt GPIO Controller

This peripheral provides 48 general-purpose lines, arranged as six 8-bit ports, behind a byte-wide register bus that decodes a 16-byte offset window. Each port has a byte-wide output latch that drives its lines. A latch bit of 0 turns the line into an input. Reading a port returns the pin levels after they pass a two-flop synchronizer.

Only the lowest 24 lines, in ports 0 to 2, can raise interrupts. Each of these lines has an enable bit, a polarity bit that selects a rising or a falling edge, and a latched pending bit. These three per-port byte registers share offsets 8 to 10. A page byte written at offset 7 chooses which of them those offsets reach. A summary byte at offset 6 shows which ports hold a pending line. A single registered interrupt output is raised while any line is pending.

Software acknowledges a line by writing its enable byte twice. The first write clears the line's bit, which discards the pending state. The second write sets the bit again.

Top module: `gpio48_edge_irq`

## Requirements
- R1: After reset, all output latches, enable, polarity and pending bits and the page byte are 0, the interrupt output is low and reads of offset 6 return 0.
- R2: A write to offset n (0 to 5) loads pin_out[8n+7:8n] in the next cycle. A read of offset n returns pin_in[8n+7:8n] as sampled through a two-flop synchronizer. Read data is registered and appears the cycle after the read strobe.
- R3: Offset 6 returns bit p (p = 0..2) set when any pending bit of port p is set. Bits 7:3 read as 0.
- R4: Offset 7 holds a page byte that reads back as written. Code 0x80 selects the enable page, 0x40 the polarity page and 0xC0 the pending page. Any other code selects no page.
- R5: A polarity bit of 1 makes its line latch on a rising synchronized edge. A bit of 0 makes it latch on a falling edge. The opposite edge latches nothing.
- R6: An edge latches only while that line's enable bit is 1. Edges seen while the bit is 0 are lost.
- R7: With the pending page selected, a read of offset 8+p returns the pending bits of port p, one bit per line.
- R8: A write on the enable page clears the pending bit of every line whose new enable bit is 0. This holds even when an edge on that line arrives in the same cycle. A line whose old and new enable bits are both 1 still latches an edge from that cycle.
- R9: The interrupt output goes high one cycle after any pending bit is set. It stays high until every pending bit is clear.
- R10: Writes to offsets 8 to 10 on the pending page, or when no page is selected, change nothing. Writes to offsets 11 to 15 have no effect, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Sensed pin levels |
| pin_out | output | 48 | Output latches driving the pins |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: an edge being latched on a line, and an enable write that acknowledges that line. The bench raises two enabled lines together. It then times an enable write so that the write is captured in the exact cycle in which the synchronized edges are first seen. That write clears one line's bit and keeps the other's. The pending page must then show only the kept line, which confirms that the clear wins for the first line and that the capture still happens for the second.

// File: rtl/gpio48_pkg.sv
package gpio48_pkg;

  localparam int PAGE_CODE_W = 8;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_EN   = 2'd1,
    PG_POL  = 2'd2,
    PG_ID   = 2'd3
  } page_e;

  function automatic page_e decode_page(input logic [PAGE_CODE_W-1:0] code);
    case (code)
      8'h80:   return PG_EN;
      8'h40:   return PG_POL;
      8'hC0:   return PG_ID;
      default: return PG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio48_sync.sv
module gpio48_sync #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio48_out_regs.sv
module gpio48_out_regs #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [NUM_PORTS*PORT_W-1:0] latches
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        latches[p*PORT_W +: PORT_W] <= '0;
      end else if (bus_wr && bus_addr == ADDR_W'(p)) begin
        latches[p*PORT_W +: PORT_W] <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/gpio48_irq_port.sv
module gpio48_irq_port #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] sense,
  input  logic              en_wr,
  input  logic              pol_wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] en,
  output logic [PORT_W-1:0] pol,
  output logic [PORT_W-1:0] pend
);
  logic [PORT_W-1:0] prev;
  logic [PORT_W-1:0] hit;
  logic [PORT_W-1:0] keep;
  logic [PORT_W-1:0] pend_nxt;

  // Each line watches for the edge its polarity bit selects.
  always_comb begin
    hit      = (pol & sense & ~prev) | (~pol & ~sense & prev);
    keep     = en_wr ? wdata : en;
    // A line whose new enable bit is 0 loses its pending state, even if an
    // edge arrives in the same cycle.
    pend_nxt = (pend | (hit & en)) & keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      en   <= '0;
      pol  <= '0;
      pend <= '0;
    end else begin
      prev <= sense;
      pend <= pend_nxt;
      if (en_wr)  en  <= wdata;
      if (pol_wr) pol <= wdata;
    end
  end
endmodule

// File: rtl/gpio48_edge_irq.sv
module gpio48_edge_irq
  import gpio48_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic                        irq
);
  localparam int LINES       = NUM_PORTS * PORT_W;
  localparam int IRQ_LINES   = IRQ_PORTS * PORT_W;
  localparam int SUMMARY_OFS = NUM_PORTS;
  localparam int PAGE_OFS    = NUM_PORTS + 1;
  localparam int BANK_OFS    = NUM_PORTS + 2;

  logic [LINES-1:0]       sensed;
  logic [PAGE_CODE_W-1:0] page_q;
  page_e                  page;
  logic [IRQ_LINES-1:0]   en_flat;
  logic [IRQ_LINES-1:0]   pol_flat;
  logic [IRQ_LINES-1:0]   pend_flat;
  logic [IRQ_PORTS-1:0]   summary;
  logic [PORT_W-1:0]      rd_mux;

  gpio48_sync #(.WIDTH(LINES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (sensed)
  );

  gpio48_out_regs #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .latches   (pin_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(PAGE_OFS)) begin
      page_q <= PAGE_CODE_W'(bus_wdata);
    end
  end

  assign page = decode_page(page_q);

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_bank
    logic sel;
    assign sel = bus_wr && bus_addr == ADDR_W'(BANK_OFS + p);

    gpio48_irq_port #(.PORT_W(PORT_W)) u_port (
      .clk    (clk),
      .rst    (rst),
      .sense  (sensed[p*PORT_W +: PORT_W]),
      .en_wr  (sel && page == PG_EN),
      .pol_wr (sel && page == PG_POL),
      .wdata  (bus_wdata),
      .en     (en_flat[p*PORT_W +: PORT_W]),
      .pol    (pol_flat[p*PORT_W +: PORT_W]),
      .pend   (pend_flat[p*PORT_W +: PORT_W])
    );

    assign summary[p] = |pend_flat[p*PORT_W +: PORT_W];
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(p)) rd_mux = sensed[p*PORT_W +: PORT_W];
    end
    if (bus_addr == ADDR_W'(SUMMARY_OFS)) rd_mux = PORT_W'(summary);
    if (bus_addr == ADDR_W'(PAGE_OFS))    rd_mux = PORT_W'(page_q);
    for (int p = 0; p < IRQ_PORTS; p++) begin
      if (bus_addr == ADDR_W'(BANK_OFS + p)) begin
        case (page)
          PG_EN:   rd_mux = en_flat[p*PORT_W +: PORT_W];
          PG_POL:  rd_mux = pol_flat[p*PORT_W +: PORT_W];
          PG_ID:   rd_mux = pend_flat[p*PORT_W +: PORT_W];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= |pend_flat;
    end
  end
endmodule

// File: rtl/gpio48_edge_irq_chk.sv
module gpio48_edge_irq_chk #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [PORT_W-1:0]           bus_rdata,
  input logic [7:0]                  page_q,
  input logic [IRQ_PORTS*PORT_W-1:0] en_flat,
  input logic [IRQ_PORTS*PORT_W-1:0] pend_flat,
  input logic                        irq
);
  localparam int SUMMARY_OFS = NUM_PORTS;
  localparam int PAGE_OFS    = NUM_PORTS + 1;
  localparam int FIRST_UNDEC = NUM_PORTS + 2 + IRQ_PORTS;

  // R6
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_flat & ~en_flat) == '0);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend_flat) |=> irq);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_flat == '0) |=> !irq);

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(PAGE_OFS)) |=> $stable(page_q));

  // R3
  summary_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(SUMMARY_OFS)) |=> bus_rdata[PORT_W-1:IRQ_PORTS] == '0);

  // R10
  undecoded_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= ADDR_W'(FIRST_UNDEC)) |=> bus_rdata == '0);
endmodule

bind gpio48_edge_irq gpio48_edge_irq_chk #(
  .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .page_q    (page_q),
  .en_flat   (en_flat),
  .pend_flat (pend_flat),
  .irq       (irq)
);

// File: tb/test_gpio48_edge_irq.sv
`timescale 1ns/1ps
module test_gpio48_edge_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio48_edge_irq i_gpio48_edge_irq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pin_out", pin_out, 48'h0);
    check("R1 irq", irq, 1'b0);
    bus_read(4'd6, d);
    check("R1 summary", d, 8'h00);
    bus_read(4'd7, d);
    check("R1 page", d, 8'h00);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    bus_write(4'd3, 8'hA5);
    check("R2 latch port3", pin_out[31:24], 8'hA5);
    check("R2 other ports", {pin_out[47:32], pin_out[23:0]}, 40'h0);
    pin_in[47:40] = 8'h3C;
    wait_cycles(3);
    bus_read(4'd5, d);
    check("R2 read port5", d, 8'h3C);
    pin_in[47:40] = 8'h00;
    wait_cycles(3);
  endtask

  task automatic t_pages();
    logic [7:0] d;
    bus_write(4'd7, 8'h40);
    bus_read(4'd7, d);
    check("R4 page readback", d, 8'h40);
    bus_write(4'd7, 8'h00);
    bus_write(4'd8, 8'hFF);
    bus_write(4'd7, 8'h80);
    bus_read(4'd8, d);
    check("R10 no-page write ignored", d, 8'h00);
    bus_write(4'd12, 8'hFF);
    bus_read(4'd12, d);
    check("R10 undecoded read", d, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    // Line 23 rises while its enable bit is 0, so nothing is latched.
    pin_in[23] = 1'b1;
    wait_cycles(5);
    bus_write(4'd7, 8'h40);
    bus_write(4'd8, 8'h01);
    bus_write(4'd10, 8'h00);
    bus_write(4'd7, 8'h80);
    bus_write(4'd8, 8'h01);
    bus_write(4'd10, 8'h80);
    check("R6 disabled edge lost", irq, 1'b0);
    pin_in[0] = 1'b1;
    pin_in[1] = 1'b1;
    pin_in[23] = 1'b0;
    wait_cycles(6);
    check("R9 irq set", irq, 1'b1);
    bus_read(4'd6, d);
    check("R3 summary", d, 8'h05);
    bus_write(4'd7, 8'hC0);
    bus_read(4'd8, d);
    check("R5 R6 R7 port0 rising", d, 8'h01);
    bus_read(4'd10, d);
    check("R5 R7 port2 falling", d, 8'h80);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    bus_write(4'd8, 8'hFF);
    bus_read(4'd8, d);
    check("R10 ID write ignored", d, 8'h01);
    bus_write(4'd7, 8'h80);
    bus_write(4'd8, 8'h00);
    bus_write(4'd8, 8'h01);
    bus_write(4'd7, 8'hC0);
    bus_read(4'd8, d);
    check("R8 ack clears", d, 8'h00);
    check("R9 irq held by port2", irq, 1'b1);
    bus_write(4'd7, 8'h80);
    bus_write(4'd10, 8'h00);
    bus_write(4'd10, 8'h80);
    wait_cycles(2);
    check("R9 irq dropped", irq, 1'b0);
    pin_in[0] = 1'b0;
    wait_cycles(6);
    check("R5 wrong edge ignored", irq, 1'b0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pin_in[1:0] = 2'b00;
    wait_cycles(4);
    bus_write(4'd7, 8'h40);
    bus_write(4'd8, 8'h03);
    bus_write(4'd7, 8'h80);
    bus_write(4'd8, 8'h03);
    // Raise both lines; the enable write is captured in the cycle the
    // synchronized edges are first seen.
    pin_in[1:0] = 2'b11;
    @(negedge clk);
    bus_write(4'd8, 8'h02);
    bus_write(4'd7, 8'hC0);
    bus_read(4'd8, d);
    check("R8 same-cycle clear wins", d, 8'h02);
    check("R9 irq for kept line", irq, 1'b1);
  endtask

  initial begin
    wait_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ports();
    t_pages();
    t_edges();
    t_ack();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule